// File: doc/BRIEF.md
# Command-Driven Byte DMA Engine

This block moves bytes between an external request/acknowledge bus and an internal endpoint buffer. A controller loads a byte count and then issues an 8-bit command. The command either starts an inbound transfer (bus to buffer) or an outbound transfer (buffer to bus), stops a running transfer, marks the transmit buffer as filled, empties it, or returns the whole engine to its power-on state. An eight-byte staging FIFO decouples the two sides. The count register reads back the number of bytes that still have to cross the external bus.

The stop command behaves differently in each direction. Inbound, the bytes already staged are still written into the buffer before the stop completes. Outbound, the staged bytes are dropped and the buffer is not released, so the untransferred data stays where it was. The transmit buffer has two halves. Filling, clearing and automatic emptying after a send all work oldest-first, so emptying both halves takes two clear commands.

Top module: `dma_cmd_engine`

## Requirements
- R1: After `rst_n` is released, and one cycle after command 11h, `remaining` is 0, `busy`, `irq_done`, `irq_stop` and `ext_req` are 0, `tx_full` is 00 and the staging FIFO is empty. While `rst_n` is low, `ext_req` stays low.
- R2: Command 00h with a loaded count N makes the engine accept N bytes from `ext_din`, one per cycle in which both `ext_req` and `ext_ack` are high. It writes them to `buf_wdata` with `buf_wr`, in arrival order, whenever `buf_ready` is high. `remaining` drops by one per accepted byte.
- R3: Inbound, at most 8 bytes are accepted ahead of the buffer. With `buf_ready` held low, `ext_req` falls after exactly 8 handshakes.
- R4: Command 01h with count N makes the engine read exactly N bytes from `buf_rdata` with `buf_rd`, and never more than `remaining`. It presents them in order on `ext_dout`, and each one is delivered by an `ext_req`/`ext_ack` handshake that lowers `remaining` by one.
- R5: When `remaining` is 0 and the FIFO is empty, the transfer ends: `busy` falls and `irq_done` is set. An outbound transfer also pulses `out_release` once in its last busy cycle. Writing 1 to `irq_ack[0]` clears `irq_done`, and writing 1 to `irq_ack[1]` clears `irq_stop`.
- R6: `ext_req` is high only while busy, with `remaining` nonzero and the FIFO not full (inbound) or not empty (outbound).
- R7: While busy, count writes and commands 00h/01h have no effect on the count or the direction.
- R8: Codes 02h–0Dh, 10h, 12h and 14h–FFh change no state.
- R9: Command 13h during an inbound transfer lowers `ext_req` from the next cycle, still writes every staged byte to the buffer, then ends the transfer with `irq_stop` set, `irq_done` clear and `remaining` holding the bytes not received.
- R10: Command 13h during an outbound transfer ends it in the next cycle with `irq_stop` set, discards the staged bytes and does not pulse `out_release`. `remaining` keeps the count of bytes not delivered.
- R11: Command 0Eh marks the next empty transmit half full, alternating halves (`tx_full` bit 0 first), and is ignored when that half is already full. Command 0Fh empties the oldest full half. With both halves full it takes two of them to reach 00. Neither affects a running transfer.
- R12: A high `tx_sent` empties the oldest full transmit half, as 0Fh does.
- R13: Command 13h while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| cnt_wr | input | 1 | Byte count write strobe (idle only) |
| cnt_wdata | input | 32 | Byte count to load |
| irq_ack | input | 2 | Write-one-to-clear: bit 0 done, bit 1 stop |
| ext_req | output | 1 | External bus byte request |
| ext_ack | input | 1 | External bus acknowledge |
| ext_din | input | 8 | Inbound byte from external bus |
| ext_dout | output | 8 | Outbound byte to external bus |
| buf_wr | output | 1 | Write strobe into endpoint buffer |
| buf_wdata | output | 8 | Byte written into endpoint buffer |
| buf_ready | input | 1 | Endpoint buffer can take a byte |
| buf_rd | output | 1 | Read strobe from endpoint buffer |
| buf_rdata | input | 8 | Byte read from endpoint buffer |
| buf_avail | input | 1 | Endpoint buffer has a byte to give |
| out_release | output | 1 | Outbound data fully sent; buffer may be freed |
| tx_sent | input | 1 | Transmit half sent on the link |
| tx_full | output | 2 | Full flag per transmit half |
| remaining | output | 32 | Bytes still to cross the external bus |
| busy | output | 1 | Transfer in progress |
| irq_done | output | 1 | Transfer-complete interrupt flag |
| irq_stop | output | 1 | Stop-complete interrupt flag |

## Verification
Both directions run for every count from 0 to 12. The runs use three duty patterns for the buffer side and for the bus acknowledge, so that counts below, at and above the FIFO depth meet both a slow sink and a slow source. Byte order, the exact number of buffer reads and the per-cycle `remaining` value separate a correct engine from one that over-fetches, drops, reorders or miscounts. All 250 reserved codes are swept from idle. Separate sequences check stop in each direction, soft reset in mid-transfer, and the half-by-half transmit flags. Each of these sequences is followed by a fresh transfer, which exposes stale FIFO contents.

// File: rtl/dma_cmd_pkg.sv
`timescale 1ns/100ps
package dma_cmd_pkg;
    localparam logic [7:0] CODE_IN       = 8'h00;
    localparam logic [7:0] CODE_OUT      = 8'h01;
    localparam logic [7:0] CODE_VALIDATE = 8'h0E;
    localparam logic [7:0] CODE_CLEAR    = 8'h0F;
    localparam logic [7:0] CODE_RESET    = 8'h11;
    localparam logic [7:0] CODE_STOP     = 8'h13;

    typedef enum logic [2:0] {
        OP_NONE, OP_IN, OP_OUT, OP_VALIDATE, OP_CLEAR, OP_RESET, OP_STOP
    } dma_op_e;
endpackage

// File: rtl/dma_cmd_decode.sv
`timescale 1ns/100ps
module dma_cmd_decode
    import dma_cmd_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    output dma_op_e    op
);
    always_comb begin
        op = OP_NONE;
        if (cmd_valid) begin
            case (cmd_code)
                CODE_IN:       op = OP_IN;
                CODE_OUT:      op = OP_OUT;
                CODE_VALIDATE: op = OP_VALIDATE;
                CODE_CLEAR:    op = OP_CLEAR;
                CODE_RESET:    op = OP_RESET;
                CODE_STOP:     op = OP_STOP;
                default:       op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dma_stage_fifo.sv
`timescale 1ns/100ps
module dma_stage_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          p_q, p_d;
    logic [W-1:0]  mem [DEPTH];
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_push = push && (p_q.cnt != CW'(DEPTH));
        do_pop  = pop && (p_q.cnt != '0);
        p_d     = p_q;
        if (do_push) p_d.wr = step(p_q.wr);
        if (do_pop)  p_d.rd = step(p_q.rd);
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
        if (flush) p_d = '0;
        dout  = mem[p_q.rd];
        count = p_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (do_push && p_q.wr == PW'(i)) mem[i] <= din;
        end
    end
endmodule

// File: rtl/dma_txbuf_track.sv
`timescale 1ns/100ps
module dma_txbuf_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       fill,
    input  logic       empty_one,
    input  logic       sent,
    output logic [1:0] full
);
    typedef struct packed {
        logic [1:0] full;
        logic       head;
        logic       tail;
    } tx_t;

    tx_t  t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (fill && !t_q.full[t_q.tail]) begin
            t_d.full[t_q.tail] = 1'b1;
            t_d.tail           = ~t_q.tail;
        end
        if ((empty_one || sent) && t_q.full[t_q.head]) begin
            t_d.full[t_q.head] = 1'b0;
            t_d.head           = ~t_q.head;
        end
        if (soft_rst) t_d = '0;
        full = t_q.full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/dma_cmd_engine.sv
`timescale 1ns/100ps
module dma_cmd_engine
    import dma_cmd_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic [1:0]        irq_ack,
    output logic              ext_req,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_din,
    output logic [DATA_W-1:0] ext_dout,
    output logic              buf_wr,
    output logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_ready,
    output logic              buf_rd,
    input  logic [DATA_W-1:0] buf_rdata,
    input  logic              buf_avail,
    output logic              out_release,
    input  logic              tx_sent,
    output logic [1:0]        tx_full,
    output logic [CNT_W-1:0]  remaining,
    output logic              busy,
    output logic              irq_done,
    output logic              irq_stop
);
    localparam int FCW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic [CNT_W-1:0] remaining;
        logic             active;
        logic             dir_in;
        logic             stopping;
        logic             irq_done;
        logic             irq_stop;
    } state_t;

    state_t            st_q, st_d;
    dma_op_e           op;
    logic [FCW-1:0]    fifo_cnt;
    logic [DATA_W-1:0] fifo_dout, fifo_din;
    logic              fifo_push, fifo_pop, fifo_flush;
    logic              fifo_empty, fifo_full, staged_short;
    logic              xfer, finish, soft_rst;

    dma_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .op        (op)
    );

    dma_stage_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (fifo_flush),
        .push  (fifo_push),
        .din   (fifo_din),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .count (fifo_cnt)
    );

    dma_txbuf_track u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .fill      (op == OP_VALIDATE),
        .empty_one (op == OP_CLEAR),
        .sent      (tx_sent),
        .full      (tx_full)
    );

    always_comb begin
        soft_rst     = (op == OP_RESET);
        fifo_empty   = (fifo_cnt == '0);
        fifo_full    = (fifo_cnt == FCW'(FIFO_DEPTH));
        staged_short = st_q.remaining > CNT_W'(fifo_cnt);

        ext_req = st_q.active && !st_q.stopping && (st_q.remaining != '0) &&
                  (st_q.dir_in ? !fifo_full : !fifo_empty);
        xfer    = ext_req && ext_ack;
        buf_rd  = st_q.active && !st_q.stopping && !st_q.dir_in &&
                  buf_avail && !fifo_full && staged_short;
        buf_wr  = st_q.active && st_q.dir_in && !fifo_empty && buf_ready;

        buf_wdata = fifo_dout;
        ext_dout  = fifo_dout;
        fifo_push = st_q.dir_in ? xfer    : buf_rd;
        fifo_din  = st_q.dir_in ? ext_din : buf_rdata;
        fifo_pop  = st_q.dir_in ? buf_wr  : xfer;

        finish      = st_q.active && !st_q.stopping &&
                      (st_q.remaining == '0) && fifo_empty;
        out_release = finish && !st_q.dir_in;

        st_d       = st_q;
        fifo_flush = soft_rst;
        st_d.irq_done = st_q.irq_done & ~irq_ack[0];
        st_d.irq_stop = st_q.irq_stop & ~irq_ack[1];
        if (xfer) st_d.remaining = st_q.remaining - 1'b1;

        if (finish) begin
            st_d.active   = 1'b0;
            st_d.irq_done = 1'b1;
        end else if (st_q.stopping) begin
            if (fifo_empty) begin
                st_d.active   = 1'b0;
                st_d.stopping = 1'b0;
                st_d.irq_stop = 1'b1;
            end
        end else if (op == OP_STOP && st_q.active) begin
            if (st_q.dir_in) begin
                st_d.stopping = 1'b1;
            end else begin
                st_d.active   = 1'b0;
                st_d.irq_stop = 1'b1;
                fifo_flush    = 1'b1;
            end
        end

        if (!st_q.active) begin
            if (cnt_wr) st_d.remaining = cnt_wdata;
            if (op == OP_IN || op == OP_OUT) begin
                st_d.active = 1'b1;
                st_d.dir_in = (op == OP_IN);
            end
        end

        if (soft_rst) st_d = '0;

        remaining = st_q.remaining;
        busy      = st_q.active;
        irq_done  = st_q.irq_done;
        irq_stop  = st_q.irq_stop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dma_cmd_engine_chk.sv
`timescale 1ns/100ps
module dma_cmd_engine_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [7:0]       cmd_code,
    input logic             cnt_wr,
    input logic             ext_req,
    input logic             ext_ack,
    input logic             buf_rd,
    input logic             buf_wr,
    input logic             out_release,
    input logic             tx_sent,
    input logic [1:0]       tx_full,
    input logic [CNT_W-1:0] remaining,
    input logic             busy,
    input logic             irq_done,
    input logic             irq_stop
);
    logic rst_cmd, reserved;
    always_comb begin
        rst_cmd  = cmd_valid && cmd_code == 8'h11;
        reserved = cmd_valid && !(cmd_code == 8'h00 || cmd_code == 8'h01 ||
                   cmd_code == 8'h0E || cmd_code == 8'h0F ||
                   cmd_code == 8'h11 || cmd_code == 8'h13);
    end

    assert_req_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ext_req);

    assert_req_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> remaining != '0);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && ext_ack && !rst_cmd) |=> remaining == $past(remaining) - 1'b1);

    assert_fetch_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |-> (busy && !buf_wr));

    assert_release_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_release && !rst_cmd) |=> (!busy && irq_done));

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_wr && !(ext_req && ext_ack) && !rst_cmd)
        |=> remaining == $past(remaining));

    assert_reserved_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reserved) |=> !busy);

    assert_soft_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (remaining == '0 && !busy && tx_full == 2'b00 &&
                     !irq_done && !irq_stop));

    assert_clear_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 8'h0F && tx_full == 2'b11 && !tx_sent)
        |=> $countones(tx_full) == 1);
endmodule

bind dma_cmd_engine dma_cmd_engine_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cnt_wr      (cnt_wr),
    .ext_req     (ext_req),
    .ext_ack     (ext_ack),
    .buf_rd      (buf_rd),
    .buf_wr      (buf_wr),
    .out_release (out_release),
    .tx_sent     (tx_sent),
    .tx_full     (tx_full),
    .remaining   (remaining),
    .busy        (busy),
    .irq_done    (irq_done),
    .irq_stop    (irq_stop)
);

// File: tb/dma_cmd_engine_test.sv
`timescale 1ns/100ps
module dma_cmd_engine_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [7:0]  cmd_code;
    logic        cnt_wr;
    logic [31:0] cnt_wdata;
    logic [1:0]  irq_ack;
    logic        ext_req, ext_ack;
    logic [7:0]  ext_din, ext_dout;
    logic        buf_wr, buf_ready, buf_rd, buf_avail;
    logic [7:0]  buf_wdata, buf_rdata;
    logic        out_release, tx_sent;
    logic [1:0]  tx_full;
    logic [31:0] remaining;
    logic        busy, irq_done, irq_stop;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    dma_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .irq_ack(irq_ack),
        .ext_req(ext_req), .ext_ack(ext_ack), .ext_din(ext_din), .ext_dout(ext_dout),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_ready(buf_ready),
        .buf_rd(buf_rd), .buf_rdata(buf_rdata), .buf_avail(buf_avail),
        .out_release(out_release), .tx_sent(tx_sent), .tx_full(tx_full),
        .remaining(remaining), .busy(busy), .irq_done(irq_done), .irq_stop(irq_stop)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        cmd_valid = 0; cmd_code = 0; cnt_wr = 0; cnt_wdata = 0; irq_ack = 0;
        ext_ack = 0; ext_din = 0; buf_ready = 0; buf_rdata = 0; buf_avail = 0;
        tx_sent = 0;
    endtask

    task automatic send_cmd(input logic [7:0] code);
        @(negedge clk);
        cmd_valid = 1; cmd_code = code;
        @(negedge clk);
        cmd_valid = 0;
        #1;
    endtask

    task automatic start(input logic [7:0] code, input int n);
        @(negedge clk);
        cnt_wr = 1; cnt_wdata = n; cmd_valid = 1; cmd_code = code;
        @(negedge clk);
        cnt_wr = 0; cmd_valid = 0;
    endtask

    task automatic ack_irq(input logic [1:0] bits);
        @(negedge clk);
        irq_ack = bits;
        @(negedge clk);
        irq_ack = 0;
        #1;
    endtask

    function automatic bit duty(input int mode, input int cyc);
        case (mode)
            0:       return 1'b1;
            1:       return (cyc % 2) == 0;
            default: return (cyc % 3) == 2;
        endcase
    endfunction

    // R2 inbound run with duty patterns on buffer side and bus acknowledge
    task automatic run_in(input int n, input int rmode, input int amode, input logic [7:0] base);
        int sent = 0, got = 0, cyc = 0;
        bit order_ok = 1, rem_ok = 1;
        start(8'h00, n);
        while (busy && cyc < 600) begin
            ext_ack   = duty(amode, cyc);
            buf_ready = duty(rmode, cyc);
            ext_din   = base + 8'(sent);
            #1;
            if (remaining != 32'(n - sent)) rem_ok = 0;
            if (ext_req && sent >= n) rem_ok = 0;
            if (ext_req && ext_ack) sent++;
            if (buf_wr) begin
                if (buf_wdata != base + 8'(got)) order_ok = 0;
                got++;
            end
            @(negedge clk);
            cyc++;
        end
        ext_ack = 0; buf_ready = 0;
        #1;
        check(got == n, "R2 inbound byte count", got, n);
        check(order_ok, "R2 inbound byte order", 0, 1);
        check(rem_ok, "R2/R6 remaining countdown", 0, 1);
        check(!busy && irq_done && remaining == 0, "R5 inbound completion",
              {busy, irq_done}, 2'b01);
        ack_irq(2'b01);
        check(!irq_done, "R5 done cleared by ack", irq_done, 0);
    endtask

    // R4 outbound run with a bus acknowledge duty pattern
    task automatic run_out(input int n, input int amode, input logic [7:0] base);
        int fetched = 0, deliv = 0, rel = 0, cyc = 0;
        bit order_ok = 1, rem_ok = 1;
        start(8'h01, n);
        while (busy && cyc < 600) begin
            buf_avail = 1;
            buf_rdata = base + 8'(fetched);
            ext_ack   = duty(amode, cyc);
            #1;
            if (remaining != 32'(n - deliv)) rem_ok = 0;
            if (buf_rd) fetched++;
            if (ext_req && ext_ack) begin
                if (ext_dout != base + 8'(deliv)) order_ok = 0;
                deliv++;
            end
            if (out_release) rel++;
            @(negedge clk);
            cyc++;
        end
        ext_ack = 0; buf_avail = 0;
        #1;
        check(fetched == n, "R4 outbound buffer reads", fetched, n);
        check(deliv == n, "R4 outbound deliveries", deliv, n);
        check(order_ok, "R4 outbound byte order", 0, 1);
        check(rem_ok, "R4 remaining countdown", 0, 1);
        check(rel == 1, "R5 single release pulse", rel, 1);
        check(!busy && irq_done && remaining == 0, "R5 outbound completion",
              {busy, irq_done}, 2'b01);
        ack_irq(2'b01);
    endtask

    initial begin
        #(5.0 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        if (!done_flag) $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        quiet();
        rst_n = 0;
        repeat (3) @(negedge clk);
        #1;
        check(!ext_req, "R1 request low in reset", ext_req, 0);
        rst_n = 1;
        @(negedge clk); #1;
        check(remaining == 0 && !busy && !irq_done && !irq_stop && tx_full == 0 && !ext_req,
              "R1 power-on state", {remaining[3:0], busy, irq_done, irq_stop, tx_full}, 0);

        // sweep counts and duty patterns in both directions
        for (int n = 0; n <= 12; n++) begin
            for (int m = 0; m < 3; m++) begin
                run_in(n, m, (m + 1) % 3, 8'(8'h10 * m + n));
                run_out(n, m, 8'(8'h80 + 8'h10 * m + n));
            end
        end

        // R3: FIFO bound with a stalled buffer
        begin
            int acc = 0;
            start(8'h00, 12);
            for (int c = 0; c < 16; c++) begin
                ext_ack = 1; ext_din = 8'(c);
                #1;
                if (ext_req) acc++;
                @(negedge clk);
            end
            ext_ack = 0; #1;
            check(acc == 8, "R3 bytes staged with buffer stalled", acc, 8);
            check(!ext_req, "R3 request low when FIFO full", ext_req, 0);
            check(remaining == 4, "R3 remaining after stall", remaining, 4);
            send_cmd(8'h13);
            buf_ready = 1;
            repeat (12) @(negedge clk);
            buf_ready = 0; #1;
            ack_irq(2'b10);
        end

        // R9: inbound stop flushes staged bytes into buffer
        begin
            int got = 0, cyc = 0;
            bit order_ok = 1;
            start(8'h00, 20);
            for (int c = 0; c < 5; c++) begin
                ext_ack = 1; ext_din = 8'hC0 + 8'(c);
                @(negedge clk);
            end
            ext_ack = 0;
            cmd_valid = 1; cmd_code = 8'h13;
            @(negedge clk);
            cmd_valid = 0; ext_ack = 1;
            #1;
            check(!ext_req, "R9 request drops after stop", ext_req, 0);
            check(busy, "R9 still draining", busy, 1);
            while (busy && cyc < 50) begin
                buf_ready = 1;
                #1;
                if (buf_wr) begin
                    if (buf_wdata != 8'hC0 + 8'(got)) order_ok = 0;
                    got++;
                end
                @(negedge clk);
                cyc++;
            end
            ext_ack = 0; buf_ready = 0; #1;
            check(got == 5, "R9 staged bytes written on stop", got, 5);
            check(order_ok, "R9 flush order", 0, 1);
            check(irq_stop && !irq_done, "R9 stop flag only", {irq_stop, irq_done}, 2'b10);
            check(remaining == 15, "R9 remaining after stop", remaining, 15);
            ack_irq(2'b10);
            check(!irq_stop, "R5 stop flag cleared by ack", irq_stop, 0);
        end

        // R10: outbound stop discards staged bytes, no release
        begin
            int rel = 0;
            start(8'h01, 20);
            for (int c = 0; c < 12; c++) begin
                buf_avail = 1; buf_rdata = 8'hE0 + 8'(c);
                #1;
                if (out_release) rel++;
                @(negedge clk);
            end
            buf_avail = 0;
            cmd_valid = 1; cmd_code = 8'h13;
            #1;
            if (out_release) rel++;
            @(negedge clk);
            cmd_valid = 0; #1;
            check(!busy && irq_stop && !irq_done, "R10 outbound stop completes",
                  {busy, irq_stop, irq_done}, 3'b010);
            check(remaining == 20, "R10 remaining after stop", remaining, 20);
            check(rel == 0 && !out_release, "R10 no release on stop", rel, 0);
            ack_irq(2'b10);
            run_out(3, 0, 8'h55);
        end

        // R7 busy-ignore, R11 clear during transfer
        begin
            start(8'h00, 10);
            @(negedge clk);
            cnt_wr = 1; cnt_wdata = 99; cmd_valid = 1; cmd_code = 8'h01;
            @(negedge clk);
            cnt_wr = 0; cmd_valid = 0; #1;
            check(remaining == 10, "R7 count write ignored while busy", remaining, 10);
            check(busy && ext_req, "R7 direction kept while busy", {busy, ext_req}, 2'b11);
            send_cmd(8'h0F);
            check(remaining == 10 && busy, "R11 clear leaves transfer alone", remaining, 10);
            send_cmd(8'h13);
            repeat (3) @(negedge clk);
            #1;
            check(!busy && irq_stop, "R9 stop with empty FIFO", {busy, irq_stop}, 2'b01);
            ack_irq(2'b10);
        end

        // R13: stop while idle
        send_cmd(8'h13);
        check(!irq_stop && !busy, "R13 idle stop ignored", {irq_stop, busy}, 0);

        // R11/R12 transmit halves
        send_cmd(8'h0E);
        check(tx_full == 2'b01, "R11 first fill", tx_full, 2'b01);
        send_cmd(8'h0E);
        check(tx_full == 2'b11, "R11 second fill", tx_full, 2'b11);
        send_cmd(8'h0E);
        check(tx_full == 2'b11, "R11 fill ignored when full", tx_full, 2'b11);
        send_cmd(8'h0F);
        check(tx_full == 2'b10, "R11 first clear empties oldest", tx_full, 2'b10);
        send_cmd(8'h0F);
        check(tx_full == 2'b00, "R11 second clear empties both", tx_full, 2'b00);
        send_cmd(8'h0F);
        check(tx_full == 2'b00, "R11 clear on empty", tx_full, 2'b00);
        send_cmd(8'h0E);
        check(tx_full == 2'b01, "R11 fill after wrap", tx_full, 2'b01);
        send_cmd(8'h0E);
        @(negedge clk);
        tx_sent = 1;
        @(negedge clk);
        tx_sent = 0; #1;
        check(tx_full == 2'b10, "R12 sent empties oldest half", tx_full, 2'b10);
        @(negedge clk);
        tx_sent = 1;
        @(negedge clk);
        tx_sent = 0; #1;
        check(tx_full == 2'b00, "R12 second send empties", tx_full, 2'b00);

        // R1: soft reset mid-transfer
        send_cmd(8'h0E);
        start(8'h00, 5);
        for (int c = 0; c < 2; c++) begin
            ext_ack = 1; ext_din = 8'h77;
            @(negedge clk);
        end
        ext_ack = 0;
        send_cmd(8'h11);
        check(remaining == 0 && !busy && tx_full == 0 && !ext_req && !irq_done && !irq_stop,
              "R1 soft reset state", {remaining[3:0], busy, tx_full}, 0);
        run_in(3, 0, 0, 8'h30);

        // R8: reserved code sweep from idle
        @(negedge clk);
        cnt_wr = 1; cnt_wdata = 7;
        @(negedge clk);
        cnt_wr = 0;
        for (int code = 0; code < 256; code++) begin
            if (code == 8'h00 || code == 8'h01 || code == 8'h0E ||
                code == 8'h0F || code == 8'h11 || code == 8'h13) continue;
            send_cmd(8'(code));
            check(!busy && remaining == 7 && tx_full == 0 && !irq_done && !irq_stop,
                  $sformatf("R8 reserved code %02h", code),
                  {remaining[3:0], busy, tx_full}, {4'd7, 3'b000});
        end

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule